// File: doc/BRIEF.md
# Digital Proportional-Integral Loop Filter with Bandwidth Select

This block is the loop filter of a type-II phase-locked loop, written as digital logic so that no external analog filter parts are needed. Each valid cycle it takes one signed phase-error sample. A proportional (feedforward) path scales that sample and passes it straight to the output. An integral path adds a scaled copy of the sample into a wide accumulator. The two terms are added at a common fixed-point scale, rounded to a narrower tuning word and registered for the varactor DAC stage that follows.

All gains are powers of two. A two-bit bandwidth select picks one of four loop bandwidths, each double the one below it. Each step up doubles the proportional gain and quadruples the integral gain. Proportional gain tracks bandwidth and integral gain tracks its square, so the ratio that keeps jitter peaking under about 0.1 dB holds at every setting. The accumulator clamps at its signed limits instead of wrapping. A synchronous clear empties it. Nothing changes on a cycle without a valid sample.

Top module: `pi_loop_filter`

## Requirements
- R1: After reset, `integ_acc` and `tune_word` are zero and `tune_vld` is low.
- R2: On a valid cycle without clear, the integral accumulator grows by `phase_err * 4^bw_sel`. `bw_sel` codes 0, 1, 2 and 3 select the lowest to the highest bandwidth, each step doubling it.
- R3: The accumulator saturates at the signed limits of ACC_W bits, -2^(ACC_W-1) and 2^(ACC_W-1)-1, and never wraps.
- R4: The proportional term adds `phase_err * 2^(I_SHIFT0 - P_SHIFT0 + bw_sel)` to the updated accumulator. Their sum, divided by 2^I_SHIFT0, is the tuning value registered on that cycle.
- R5: The division by 2^I_SHIFT0 rounds to nearest with ties toward plus infinity. That is, 2^(I_SHIFT0-1) is added and the result is floored.
- R6: The rounded tuning value saturates at the signed limits of OUT_W bits.
- R7: A cycle with `clear` high sets `integ_acc` and `tune_word` to zero on the next edge, whatever `valid_in` is.
- R8: A cycle with neither `valid_in` nor `clear` leaves `integ_acc` and `tune_word` unchanged.
- R9: `tune_vld` is high for exactly the cycles that follow a cycle with `valid_in` high and `clear` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| valid_in | input | 1 | Phase-error sample valid; gates every update |
| clear | input | 1 | Synchronous clear of accumulator and tuning word |
| bw_sel | input | 2 | Bandwidth code, 0 lowest to 3 highest |
| phase_err | input | IN_W (12) | Signed phase-error sample |
| integ_acc | output | ACC_W (22) | Signed integral accumulator |
| tune_word | output | OUT_W (12) | Signed rounded tuning word |
| tune_vld | output | 1 | Tuning word updated on the last edge |

## Verification
The bench keeps the default parameters: 12-bit error, 22-bit accumulator, 12-bit output, and base shifts of 3 for the proportional path and 8 for the integral path. With these values, full-scale error at the top bandwidth setting drives the accumulator into either clamp in about sixteen samples. A one-sample error at the lowest setting lands close to the rounding boundary. The accumulator range divided by 256 is larger than the 12-bit output range, so output clamping is reached long before accumulator clamping. Random error, bandwidth, clear and idle cycles then mix these regions.

// File: rtl/lf_pkg.sv
package lf_pkg;
  localparam int SH_W = 5;

  typedef enum logic [1:0] {
    BW_X1 = 2'd0,
    BW_X2 = 2'd1,
    BW_X4 = 2'd2,
    BW_X8 = 2'd3
  } bw_code_e;

  typedef struct packed {
    logic [SH_W-1:0] prop_lsh;
    logic [SH_W-1:0] int_lsh;
  } gain_shift_t;
endpackage

// File: rtl/lf_gain_sel.sv
module lf_gain_sel
  import lf_pkg::*;
#(
  parameter int P_SHIFT0 = 3,
  parameter int I_SHIFT0 = 8
) (
  input  logic [1:0]  bw_sel,
  output gain_shift_t gains
);
  localparam int BASE_LSH = I_SHIFT0 - P_SHIFT0;

  bw_code_e code;

  always_comb begin
    code = bw_code_e'(bw_sel);
    unique case (code)
      BW_X1: begin
        gains.prop_lsh = SH_W'(BASE_LSH);
        gains.int_lsh  = SH_W'(0);
      end
      BW_X2: begin
        gains.prop_lsh = SH_W'(BASE_LSH + 1);
        gains.int_lsh  = SH_W'(2);
      end
      BW_X4: begin
        gains.prop_lsh = SH_W'(BASE_LSH + 2);
        gains.int_lsh  = SH_W'(4);
      end
      default: begin
        gains.prop_lsh = SH_W'(BASE_LSH + 3);
        gains.int_lsh  = SH_W'(6);
      end
    endcase
  end
endmodule

// File: rtl/lf_integrator.sv
module lf_integrator
  import lf_pkg::*;
#(
  parameter int IN_W  = 12,
  parameter int ACC_W = 22
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    clear,
  input  logic signed [IN_W-1:0]  err,
  input  logic [SH_W-1:0]         int_lsh,
  output logic signed [ACC_W-1:0] acc_q,
  output logic signed [ACC_W-1:0] acc_nxt
);
  localparam int SUM_W = ACC_W + 2;
  localparam logic signed [SUM_W-1:0] LIM_HI =
    {{(SUM_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] LIM_LO = ~LIM_HI;

  logic signed [SUM_W-1:0] inc;
  logic signed [SUM_W-1:0] raw;

  always_comb begin
    inc = {{(SUM_W-IN_W){err[IN_W-1]}}, err} <<< int_lsh;
    raw = {{(SUM_W-ACC_W){acc_q[ACC_W-1]}}, acc_q} + inc;
    if (raw > LIM_HI) begin
      acc_nxt = LIM_HI[ACC_W-1:0];
    end else if (raw < LIM_LO) begin
      acc_nxt = LIM_LO[ACC_W-1:0];
    end else begin
      acc_nxt = raw[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (clear) begin
      acc_q <= '0;
    end else if (en) begin
      acc_q <= acc_nxt;
    end
  end
endmodule

// File: rtl/lf_combine.sv
module lf_combine
  import lf_pkg::*;
#(
  parameter int IN_W     = 12,
  parameter int ACC_W    = 22,
  parameter int OUT_W    = 12,
  parameter int I_SHIFT0 = 8
) (
  input  logic signed [IN_W-1:0]  err,
  input  logic signed [ACC_W-1:0] acc,
  input  logic [SH_W-1:0]         prop_lsh,
  output logic signed [OUT_W-1:0] tune
);
  localparam int CW = ACC_W + 4;
  localparam logic signed [CW-1:0] HALF =
    {{(CW-I_SHIFT0){1'b0}}, 1'b1, {(I_SHIFT0-1){1'b0}}};
  localparam logic signed [CW-1:0] OUT_HI =
    {{(CW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [CW-1:0] OUT_LO = ~OUT_HI;

  logic signed [CW-1:0] prop;
  logic signed [CW-1:0] total;
  logic signed [CW-1:0] scaled;

  always_comb begin
    prop   = {{(CW-IN_W){err[IN_W-1]}}, err} <<< prop_lsh;
    total  = {{(CW-ACC_W){acc[ACC_W-1]}}, acc} + prop;
    scaled = (total + HALF) >>> I_SHIFT0;
    if (scaled > OUT_HI) begin
      tune = OUT_HI[OUT_W-1:0];
    end else if (scaled < OUT_LO) begin
      tune = OUT_LO[OUT_W-1:0];
    end else begin
      tune = scaled[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/pi_loop_filter.sv
module pi_loop_filter
  import lf_pkg::*;
#(
  parameter int IN_W     = 12,
  parameter int ACC_W    = 22,
  parameter int OUT_W    = 12,
  parameter int P_SHIFT0 = 3,
  parameter int I_SHIFT0 = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    valid_in,
  input  logic                    clear,
  input  logic [1:0]              bw_sel,
  input  logic signed [IN_W-1:0]  phase_err,
  output logic signed [ACC_W-1:0] integ_acc,
  output logic signed [OUT_W-1:0] tune_word,
  output logic                    tune_vld
);
  gain_shift_t             gains;
  logic signed [ACC_W-1:0] acc_nxt;
  logic signed [OUT_W-1:0] tune_nxt;
  logic signed [OUT_W-1:0] tune_q;
  logic                    vld_q;
  logic                    take;

  assign take = valid_in & ~clear;

  lf_gain_sel #(.P_SHIFT0(P_SHIFT0), .I_SHIFT0(I_SHIFT0)) u_gain (
    .bw_sel (bw_sel),
    .gains  (gains)
  );

  lf_integrator #(.IN_W(IN_W), .ACC_W(ACC_W)) u_int (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (take),
    .clear   (clear),
    .err     (phase_err),
    .int_lsh (gains.int_lsh),
    .acc_q   (integ_acc),
    .acc_nxt (acc_nxt)
  );

  lf_combine #(.IN_W(IN_W), .ACC_W(ACC_W), .OUT_W(OUT_W),
               .I_SHIFT0(I_SHIFT0)) u_comb (
    .err      (phase_err),
    .acc      (acc_nxt),
    .prop_lsh (gains.prop_lsh),
    .tune     (tune_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tune_q <= '0;
    end else if (clear) begin
      tune_q <= '0;
    end else if (take) begin
      tune_q <= tune_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= take;
    end
  end

  assign tune_word = tune_q;
  assign tune_vld  = vld_q;
endmodule

// File: rtl/pi_lf_chk.sv
module pi_lf_chk #(
  parameter int IN_W  = 12,
  parameter int ACC_W = 22,
  parameter int OUT_W = 12
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    valid_in,
  input logic                    clear,
  input logic signed [IN_W-1:0]  phase_err,
  input logic signed [ACC_W-1:0] integ_acc,
  input logic signed [OUT_W-1:0] tune_word,
  input logic                    tune_vld
);
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_in && !clear) |=> ($stable(integ_acc) && $stable(tune_word))); // R8

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (integ_acc == '0 && tune_word == '0)); // R7

  AST_VLD_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && !clear) |=> tune_vld); // R9

  AST_VLD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_in && !clear) |=> !tune_vld); // R9

  AST_NO_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && !clear && !phase_err[IN_W-1]) |=> (integ_acc >= $past(integ_acc))); // R3

  AST_NO_WRAP_DN: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && !clear && phase_err[IN_W-1]) |=> (integ_acc <= $past(integ_acc))); // R3
endmodule

bind pi_loop_filter pi_lf_chk #(.IN_W(IN_W), .ACC_W(ACC_W), .OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .valid_in  (valid_in),
  .clear     (clear),
  .phase_err (phase_err),
  .integ_acc (integ_acc),
  .tune_word (tune_word),
  .tune_vld  (tune_vld)
);

// File: tb/pi_loop_filter_test.sv
module pi_loop_filter_test;
  localparam int IN_W = 12;
  localparam int ACC_W = 22;
  localparam int OUT_W = 12;
  localparam int P0 = 3;
  localparam int I0 = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_in = 1'b0;
  logic clear = 1'b0;
  logic [1:0] bw_sel = 2'd0;
  logic signed [IN_W-1:0] phase_err = '0;
  logic signed [ACC_W-1:0] integ_acc;
  logic signed [OUT_W-1:0] tune_word;
  logic tune_vld;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  longint acc_m = 0;
  longint tune_m = 0;

  always #5 clk = ~clk;

  pi_loop_filter #(.IN_W(IN_W), .ACC_W(ACC_W), .OUT_W(OUT_W),
                   .P_SHIFT0(P0), .I_SHIFT0(I0)) uut (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .clear(clear),
    .bw_sel(bw_sel), .phase_err(phase_err), .integ_acc(integ_acc),
    .tune_word(tune_word), .tune_vld(tune_vld)
  );

  function automatic longint clampv(longint v, int w);
    longint hi = (longint'(1) << (w - 1)) - 1;
    longint lo = -(longint'(1) << (w - 1));
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  function automatic longint round_out(longint acc, longint e, int bw);
    longint s = acc + e * (longint'(1) << (I0 - P0 + bw));
    return clampv((s + (longint'(1) << (I0 - 1))) >>> I0, OUT_W);
  endfunction

  task automatic check(string tag, longint got, longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step(bit v, bit c, int bw, int e, string tag);
    @(negedge clk);
    valid_in = v; clear = c; bw_sel = 2'(bw); phase_err = IN_W'(e);
    @(posedge clk);
    #2;
    if (c) begin
      acc_m = 0; tune_m = 0;
    end else if (v) begin
      acc_m = clampv(acc_m + longint'(e) * (longint'(1) << (2 * bw)), ACC_W);
      tune_m = round_out(acc_m, longint'(e), bw);
    end
    check({tag, " acc"}, longint'(integ_acc), acc_m);
    check({tag, " tune"}, longint'(tune_word), tune_m);
    check("R9 vld", longint'(tune_vld), longint'(v && !c));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(10 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int seed = $urandom(32'd1234);
    seed = 0;
    #1;
    check("R1 acc", longint'(integ_acc), 0);
    check("R1 tune", longint'(tune_word), 0);
    check("R1 vld", longint'(tune_vld), 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 acc", longint'(integ_acc), 0);

    // R5: small errors at lowest bandwidth sit near the rounding boundary
    for (int k = 0; k < 6; k++) step(1'b1, 1'b0, 0, 4, "R5 R4 R2");
    for (int k = 0; k < 6; k++) step(1'b1, 1'b0, 0, -4, "R5 R4 R2");
    step(1'b1, 1'b1, 0, 0, "R7");
    // R3 R6: upper clamp at highest bandwidth
    for (int k = 0; k < 20; k++) step(1'b1, 1'b0, 3, 2047, "R3 R6 up");
    for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 2, -700, "R8 idle");
    // R3 R6: lower clamp
    for (int k = 0; k < 40; k++) step(1'b1, 1'b0, 3, -2048, "R3 R6 dn");
    step(1'b1, 1'b1, 3, 2047, "R7 clr+vld");
    for (int b = 0; b < 4; b++) step(1'b1, 1'b0, b, 100, "R2 R4 bw");

    for (int k = 0; k < 4000; k++) begin
      int r = int'($urandom % 100);
      bit c = (r < 3);
      bit v = (r >= 20);
      int bw = int'($urandom % 4);
      int e;
      if ($urandom % 8 == 0) e = ($urandom % 2 == 0) ? 2047 : -2048;
      else e = int'($urandom % 4096) - 2048;
      step(v, c, bw, e, "R2 R4 R5 rand");
    end
    finish_run();
  end
endmodule